// File: doc/BRIEF.md
# Queue Doorbell Write Decoder

This block sits behind the register write path of a multi-queue storage controller. It watches every register write. Writes that land in the doorbell window (at or above a base offset, 0x1000 by default) are turned into per-queue events. Each doorbell is a 32-bit slot on a 4-byte stride. Even slots carry new tail positions for submission queues. Odd slots carry new head positions for completion queues. Each queue owns one pair of slots.

The block finds the queue index and checks that the queue exists. It also checks that the written position lies inside that queue's ring. An accepted submission write becomes a single pulse that tells the queue state to store the tail and tells the fetch engine to start processing that queue. An accepted completion write becomes a head-update pulse. In the same cycle the block reports two things. First, it reports whether the completion ring was full just before the update; in that case the block wakes the completion poster and gives a bitmask of every existing submission queue bound to that completion queue. Second, it reports whether an interrupt is due because entries are still pending. Writes that fail any check vanish without a trace.

The write port uses a valid/ready handshake, but ready is tied high: the block never applies back-pressure, and every write is taken in the cycle its valid is sampled. All results appear one clock later as single-cycle pulses. Queue tables (existence, ring size, completion head/tail and the binding of each submission queue to its completion queue) are read as plain level inputs in the cycle the write is taken.

Top module: `dbell_decoder`

## Requirements
- R1: A write whose address has either of the two low bits set produces no update of any kind.
- R2: A write below the doorbell base produces nothing. For a write at or above the base, bit 2 of (address − base) selects the type: 1 means a completion head update, 0 means a submission tail update. At most one of the two update pulses is high in any cycle.
- R3: The submission queue index is (address − base) >> 3, and the completion queue index is (address − base − 4) >> 3.
- R4: The written position is wr_data[15:0]; the upper data bits are ignored. The write is dropped if the index is 64 or more, or if that queue's exists bit is 0.
- R5: The write is dropped when the position is greater than or equal to the queue's ring size (a size of 0 therefore rejects every write).
- R6: An accepted submission write raises sq_upd for exactly one cycle, on the cycle after the write, with the queue index and position. This pulse is both the tail store and the processing kick.
- R7: The completion ring counts as full when ((tail + 1) mod size) equals the head held before the update. An accepted completion write to a full ring raises cq_wake with the update, and sq_wake_mask holds a 1 for every existing submission queue whose bound completion index equals the updated queue; otherwise both are zero.
- R8: An accepted completion write raises cq_irq with the update exactly when the queue's tail differs from the newly written head.
- R9: After reset, and in any cycle without an accepted write one cycle earlier, all outputs are zero; wr_ready is always 1.
- R10: Queue 0 (the admin pair at base and base+4) and queue 63 are decoded and accepted like any other queue.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_valid | input | 1 | Register write present |
| wr_ready | output | 1 | Always 1; the block never stalls a write |
| wr_addr | input | 16 | Byte offset of the register write |
| wr_data | input | 32 | Write data; only bits 15:0 are used |
| sq_exists | input | 64 | One bit per submission queue: queue is set up |
| cq_exists | input | 64 | One bit per completion queue: queue is set up |
| sq_size_tbl | input | 1024 | Ring size (entries) per submission queue, 16 bits each |
| cq_size_tbl | input | 1024 | Ring size per completion queue, 16 bits each |
| cq_head_tbl | input | 1024 | Current head per completion queue |
| cq_tail_tbl | input | 1024 | Current tail per completion queue |
| sq_cq_map | input | 384 | Completion queue index bound to each submission queue, 6 bits each |
| sq_upd | output | 1 | Pulse: store tail and kick processing |
| sq_upd_id | output | 6 | Submission queue index of the update |
| sq_upd_tail | output | 16 | New tail value |
| cq_upd | output | 1 | Pulse: store completion head |
| cq_upd_id | output | 6 | Completion queue index of the update |
| cq_upd_head | output | 16 | New head value |
| cq_wake | output | 1 | Pulse: full ring was freed; restart the completion poster |
| sq_wake_mask | output | 64 | Submission queues to reschedule with cq_wake |
| cq_irq | output | 1 | Pulse: raise the interrupt for the updated completion queue |

## Verification
A behavioural model fed the same writes and queue tables predicts every output on every clock. Directed writes cover the following cases:
- Admin pair and the last queue pair: show that the index arithmetic works at both ends.
- Misaligned offsets, offsets below the window and indices past 63: show that address screening comes before type selection.
- Positions at size − 1 and at size, and writes to queues whose exists bit is clear: separate the range check from the existence check.
- Completion rings held full (including the case where the tail wraps) against rings with room, and heads equal to or different from the tail: separate the wake decision from the interrupt decision.
- Back-to-back writes: show that each pulse lasts exactly one cycle.

// File: rtl/dbell_pkg.sv
package dbell_pkg;
  typedef enum logic [1:0] {
    DB_NONE    = 2'd0,
    DB_SQ_TAIL = 2'd1,
    DB_CQ_HEAD = 2'd2
  } db_kind_e;
endpackage

// File: rtl/dbell_addr_dec.sv
module dbell_addr_dec
  import dbell_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int NUM_Q   = 64,
  parameter int DB_BASE = 'h1000,
  localparam int QID_W  = $clog2(NUM_Q)
) (
  input  logic [ADDR_W-1:0] addr,
  output db_kind_e          kind,
  output logic [QID_W-1:0]  qid
);
  localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(DB_BASE);
  localparam logic [ADDR_W-4:0] QLIM   = (ADDR_W-3)'(NUM_Q);

  logic [ADDR_W-1:0] off;
  logic [ADDR_W-4:0] slot_pair;
  logic              aligned, in_window, in_range;

  always_comb begin
    off       = addr - BASE_V;
    slot_pair = off[ADDR_W-1:3];
    aligned   = (addr[1:0] == 2'b00);
    in_window = (addr >= BASE_V);
    in_range  = (slot_pair < QLIM);
    qid       = slot_pair[QID_W-1:0];
    if (!aligned || !in_window || !in_range) kind = DB_NONE;
    else if (off[2])                         kind = DB_CQ_HEAD;
    else                                     kind = DB_SQ_TAIL;
  end
endmodule

// File: rtl/dbell_lookup.sv
module dbell_lookup
  import dbell_pkg::*;
#(
  parameter int NUM_Q  = 64,
  parameter int SZ_W   = 16,
  localparam int QID_W = $clog2(NUM_Q)
) (
  input  db_kind_e            kind,
  input  logic [QID_W-1:0]    qid,
  input  logic [SZ_W-1:0]     pos,
  input  logic [NUM_Q-1:0]    sq_exists,
  input  logic [NUM_Q-1:0]    cq_exists,
  input  logic [NUM_Q*SZ_W-1:0] sq_size_tbl,
  input  logic [NUM_Q*SZ_W-1:0] cq_size_tbl,
  output logic [SZ_W-1:0]     sel_size,
  output logic                accept
);
  logic present;

  always_comb begin
    present  = 1'b0;
    sel_size = '0;
    unique case (kind)
      DB_SQ_TAIL: begin
        present  = sq_exists[qid];
        sel_size = sq_size_tbl[qid*SZ_W +: SZ_W];
      end
      DB_CQ_HEAD: begin
        present  = cq_exists[qid];
        sel_size = cq_size_tbl[qid*SZ_W +: SZ_W];
      end
      default: ;
    endcase
    accept = present && (pos < sel_size);
  end
endmodule

// File: rtl/dbell_cq_eval.sv
module dbell_cq_eval #(
  parameter int NUM_Q  = 64,
  parameter int SZ_W   = 16,
  localparam int QID_W = $clog2(NUM_Q)
) (
  input  logic [QID_W-1:0]        qid,
  input  logic [SZ_W-1:0]         new_head,
  input  logic [SZ_W-1:0]         ring_size,
  input  logic [NUM_Q*SZ_W-1:0]   cq_head_tbl,
  input  logic [NUM_Q*SZ_W-1:0]   cq_tail_tbl,
  input  logic [NUM_Q-1:0]        sq_exists,
  input  logic [NUM_Q*QID_W-1:0]  sq_cq_map,
  output logic                    was_full,
  output logic                    irq_need,
  output logic [NUM_Q-1:0]        bound_mask
);
  logic [SZ_W-1:0] cur_head, cur_tail;
  logic [SZ_W:0]   tail_inc, tail_next;

  always_comb begin
    cur_head  = cq_head_tbl[qid*SZ_W +: SZ_W];
    cur_tail  = cq_tail_tbl[qid*SZ_W +: SZ_W];
    tail_inc  = {1'b0, cur_tail} + 1'b1;
    tail_next = (tail_inc == {1'b0, ring_size}) ? '0 : tail_inc;
    was_full  = (tail_next == {1'b0, cur_head});
    irq_need  = (cur_tail != new_head);
  end

  for (genvar s = 0; s < NUM_Q; s++) begin : g_bind
    assign bound_mask[s] = sq_exists[s] && (sq_cq_map[s*QID_W +: QID_W] == qid);
  end
endmodule

// File: rtl/dbell_decoder.sv
module dbell_decoder
  import dbell_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32,
  parameter int NUM_Q   = 64,
  parameter int SZ_W    = 16,
  parameter int DB_BASE = 'h1000,
  localparam int QID_W  = $clog2(NUM_Q)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_valid,
  output logic                   wr_ready,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [DATA_W-1:0]      wr_data,
  input  logic [NUM_Q-1:0]       sq_exists,
  input  logic [NUM_Q-1:0]       cq_exists,
  input  logic [NUM_Q*SZ_W-1:0]  sq_size_tbl,
  input  logic [NUM_Q*SZ_W-1:0]  cq_size_tbl,
  input  logic [NUM_Q*SZ_W-1:0]  cq_head_tbl,
  input  logic [NUM_Q*SZ_W-1:0]  cq_tail_tbl,
  input  logic [NUM_Q*QID_W-1:0] sq_cq_map,
  output logic                   sq_upd,
  output logic [QID_W-1:0]       sq_upd_id,
  output logic [SZ_W-1:0]        sq_upd_tail,
  output logic                   cq_upd,
  output logic [QID_W-1:0]       cq_upd_id,
  output logic [SZ_W-1:0]        cq_upd_head,
  output logic                   cq_wake,
  output logic [NUM_Q-1:0]       sq_wake_mask,
  output logic                   cq_irq
);
  db_kind_e         kind;
  logic [QID_W-1:0] qid;
  logic [SZ_W-1:0]  pos, sel_size;
  logic             accept, was_full, irq_need, take;
  logic [NUM_Q-1:0] bound_mask;

  assign wr_ready = 1'b1;
  assign take     = wr_valid && wr_ready;
  assign pos      = wr_data[SZ_W-1:0];

  dbell_addr_dec #(.ADDR_W(ADDR_W), .NUM_Q(NUM_Q), .DB_BASE(DB_BASE)) u_dec (
    .addr(wr_addr), .kind(kind), .qid(qid)
  );

  dbell_lookup #(.NUM_Q(NUM_Q), .SZ_W(SZ_W)) u_lkp (
    .kind(kind), .qid(qid), .pos(pos),
    .sq_exists(sq_exists), .cq_exists(cq_exists),
    .sq_size_tbl(sq_size_tbl), .cq_size_tbl(cq_size_tbl),
    .sel_size(sel_size), .accept(accept)
  );

  dbell_cq_eval #(.NUM_Q(NUM_Q), .SZ_W(SZ_W)) u_cqe (
    .qid(qid), .new_head(pos), .ring_size(sel_size),
    .cq_head_tbl(cq_head_tbl), .cq_tail_tbl(cq_tail_tbl),
    .sq_exists(sq_exists), .sq_cq_map(sq_cq_map),
    .was_full(was_full), .irq_need(irq_need), .bound_mask(bound_mask)
  );

  logic sq_go, cq_go;
  assign sq_go = take && accept && (kind == DB_SQ_TAIL);
  assign cq_go = take && accept && (kind == DB_CQ_HEAD);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sq_upd       <= 1'b0;
      sq_upd_id    <= '0;
      sq_upd_tail  <= '0;
      cq_upd       <= 1'b0;
      cq_upd_id    <= '0;
      cq_upd_head  <= '0;
      cq_wake      <= 1'b0;
      sq_wake_mask <= '0;
      cq_irq       <= 1'b0;
    end else begin
      sq_upd       <= sq_go;
      sq_upd_id    <= sq_go ? qid : '0;
      sq_upd_tail  <= sq_go ? pos : '0;
      cq_upd       <= cq_go;
      cq_upd_id    <= cq_go ? qid : '0;
      cq_upd_head  <= cq_go ? pos : '0;
      cq_wake      <= cq_go && was_full;
      sq_wake_mask <= (cq_go && was_full) ? bound_mask : '0;
      cq_irq       <= cq_go && irq_need;
    end
  end

  // Size seen by the range check, kept for the bound assertion.
  logic [SZ_W-1:0] chk_size;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chk_size <= '0;
    else        chk_size <= sel_size;
  end

  assert_misaligned_drop_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_addr[1:0] != 2'b00) |=> (!sq_upd && !cq_upd));

  assert_below_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_addr < ADDR_W'(DB_BASE)) |=> (!sq_upd && !cq_upd));

  assert_one_kind_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({sq_upd, cq_upd}));

  assert_needs_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (sq_upd || cq_upd) |-> $past(wr_valid));

  assert_sq_in_ring_R5: assert property (@(posedge clk) disable iff (!rst_n)
    sq_upd |-> (sq_upd_tail < chk_size));

  assert_cq_in_ring_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cq_upd |-> (cq_upd_head < chk_size));

  assert_wake_with_upd_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ((|sq_wake_mask) || cq_wake) |-> (cq_wake && cq_upd));

  assert_irq_with_upd_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cq_irq |-> cq_upd);

  assert_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_ready);
endmodule

// File: tb/dbell_decoder_test.sv
module dbell_decoder_test;
  localparam int NQ = 64;
  localparam int SW = 16;
  localparam int QW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic            wr_valid = 1'b0;
  logic            wr_ready;
  logic [15:0]     wr_addr = '0;
  logic [31:0]     wr_data = '0;
  logic [NQ-1:0]   sq_ex = '0, cq_ex = '0;
  logic [SW-1:0]   sqsz [NQ];
  logic [SW-1:0]   cqsz [NQ];
  logic [SW-1:0]   cqhd [NQ];
  logic [SW-1:0]   cqtl [NQ];
  logic [QW-1:0]   bind_q [NQ];
  logic [NQ*SW-1:0] sqsz_f, cqsz_f, cqhd_f, cqtl_f;
  logic [NQ*QW-1:0] bind_f;

  always_comb begin
    for (int q = 0; q < NQ; q++) begin
      sqsz_f[q*SW +: SW] = sqsz[q];
      cqsz_f[q*SW +: SW] = cqsz[q];
      cqhd_f[q*SW +: SW] = cqhd[q];
      cqtl_f[q*SW +: SW] = cqtl[q];
      bind_f[q*QW +: QW] = bind_q[q];
    end
  end

  logic            sq_upd, cq_upd, cq_wake, cq_irq;
  logic [QW-1:0]   sq_upd_id, cq_upd_id;
  logic [SW-1:0]   sq_upd_tail, cq_upd_head;
  logic [NQ-1:0]   sq_wake_mask;

  dbell_decoder uut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_addr(wr_addr), .wr_data(wr_data),
    .sq_exists(sq_ex), .cq_exists(cq_ex),
    .sq_size_tbl(sqsz_f), .cq_size_tbl(cqsz_f),
    .cq_head_tbl(cqhd_f), .cq_tail_tbl(cqtl_f), .sq_cq_map(bind_f),
    .sq_upd(sq_upd), .sq_upd_id(sq_upd_id), .sq_upd_tail(sq_upd_tail),
    .cq_upd(cq_upd), .cq_upd_id(cq_upd_id), .cq_upd_head(cq_upd_head),
    .cq_wake(cq_wake), .sq_wake_mask(sq_wake_mask), .cq_irq(cq_irq)
  );

  int checks = 0, fails = 0;
  bit done = 0;
  string cur_tag = "R9", exp_tag = "R9";

  // Expected outputs, produced by the behavioural model at each rising edge.
  bit          e_sq, e_cq, e_wake, e_irq;
  int          e_sqid, e_sqv, e_cqid, e_cqv;
  logic [NQ-1:0] e_mask;

  task automatic cmp(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    int a, off, qid, v, tl, nt;
    e_sq = 0; e_cq = 0; e_wake = 0; e_irq = 0;
    e_sqid = 0; e_sqv = 0; e_cqid = 0; e_cqv = 0; e_mask = '0;
    exp_tag = cur_tag;
    if (rst_n && wr_valid) begin
      a = int'(wr_addr);
      v = int'(wr_data[15:0]);
      if (a % 4 == 0 && a >= 'h1000) begin
        off = a - 'h1000;
        if ((off / 4) % 2 == 1) begin
          qid = (a - 'h1004) / 8;
          if (qid < NQ && cq_ex[qid] && v < int'(cqsz[qid])) begin
            e_cq = 1; e_cqid = qid; e_cqv = v;
            tl = int'(cqtl[qid]);
            nt = (tl + 1) % int'(cqsz[qid]);
            if (nt == int'(cqhd[qid])) begin
              e_wake = 1;
              for (int s = 0; s < NQ; s++)
                if (sq_ex[s] && int'(bind_q[s]) == qid) e_mask[s] = 1'b1;
            end
            e_irq = (tl != v);
          end
        end else begin
          qid = off / 8;
          if (qid < NQ && sq_ex[qid] && v < int'(sqsz[qid])) begin
            e_sq = 1; e_sqid = qid; e_sqv = v;
          end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      cmp(exp_tag, "sq_upd", sq_upd, e_sq);
      if (e_sq) begin
        cmp(exp_tag, "sq_upd_id R3", sq_upd_id, e_sqid);
        cmp(exp_tag, "sq_upd_tail R6", sq_upd_tail, e_sqv);
      end
      cmp(exp_tag, "cq_upd", cq_upd, e_cq);
      if (e_cq) begin
        cmp(exp_tag, "cq_upd_id R3", cq_upd_id, e_cqid);
        cmp(exp_tag, "cq_upd_head", cq_upd_head, e_cqv);
      end
      cmp(exp_tag, "cq_wake R7", cq_wake, e_wake);
      cmp(exp_tag, "sq_wake_mask R7", sq_wake_mask, e_mask);
      cmp(exp_tag, "cq_irq R8", cq_irq, e_irq);
      cmp("R9", "wr_ready", wr_ready, 1);
    end
  end

  task automatic wr(input logic [15:0] a, input logic [31:0] d, input string tag);
    @(negedge clk);
    cur_tag = tag; wr_addr = a; wr_data = d; wr_valid = 1'b1;
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  function automatic logic [15:0] sq_slot(int q);
    return 16'('h1000 + q * 8);
  endfunction
  function automatic logic [15:0] cq_slot(int q);
    return 16'('h1004 + q * 8);
  endfunction

  initial begin
    for (int q = 0; q < NQ; q++) begin
      sqsz[q] = 16'd16; cqsz[q] = 16'd8; cqhd[q] = '0; cqtl[q] = '0; bind_q[q] = '0;
    end
    sq_ex = '1; cq_ex = '1;
    sq_ex[9] = 1'b0; cq_ex[7] = 1'b0; sq_ex[20] = 1'b0;
    bind_q[1] = 6'd3; bind_q[5] = 6'd3; bind_q[9] = 6'd3; bind_q[63] = 6'd3;
    repeat (3) @(negedge clk);
    cur_tag = "R9";
    cmp("R9", "sq_upd in reset", sq_upd, 0);
    cmp("R9", "cq_upd in reset", cq_upd, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    wr(sq_slot(0), 32'h0000_0003, "R10");          // admin submission tail
    wr(cq_slot(0), 32'h0000_0000, "R10");          // admin completion head
    wr(sq_slot(5), 32'hABCD_000F, "R4 R6");        // upper bits ignored, size-1
    wr(sq_slot(5), 32'h0000_0010, "R5");           // position == size
    wr(16'h1001, 32'h1, "R1");
    wr(16'h1006, 32'h1, "R1");
    wr(16'h0014, 32'h1, "R2");
    wr(16'h0FFC, 32'h1, "R2");
    wr(sq_slot(64), 32'h1, "R4");                  // index past range
    wr(cq_slot(64), 32'h1, "R4");
    wr(sq_slot(20), 32'h1, "R4");                  // not set up
    wr(cq_slot(7), 32'h1, "R4");
    wr(sq_slot(63), 32'h2, "R10");
    wr(cq_slot(63), 32'h7, "R10 R5");
    wr(cq_slot(63), 32'h8, "R5");

    @(negedge clk); cqtl[3] = 16'd2; cqhd[3] = 16'd0;   // not full
    wr(cq_slot(3), 32'h1, "R8");
    wr(cq_slot(3), 32'h2, "R8");                   // head == tail: no interrupt
    @(negedge clk); cqhd[3] = 16'd3;                    // (2+1)%8 == 3: full
    wr(cq_slot(3), 32'h5, "R7");
    wr(cq_slot(3), 32'h2, "R7 R8");
    @(negedge clk); cqtl[3] = 16'd7; cqhd[3] = 16'd0;   // wraps to full
    wr(cq_slot(3), 32'h4, "R7");
    @(negedge clk); cqsz[4] = 16'd0;
    wr(cq_slot(4), 32'h0, "R5");

    // Back-to-back writes: each pulse lasts a single cycle.
    @(negedge clk);
    cur_tag = "R6"; wr_valid = 1'b1; wr_addr = sq_slot(2); wr_data = 32'h4;
    @(negedge clk); cur_tag = "R3"; wr_addr = cq_slot(2); wr_data = 32'h1;
    @(negedge clk); cur_tag = "R3"; wr_addr = sq_slot(1); wr_data = 32'h9;
    @(negedge clk); wr_valid = 1'b0; cur_tag = "R9";
    repeat (3) @(negedge clk);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule